// File: doc/BRIEF.md
# PWM-synchronized ADC trigger generator

This block lets conversions of an analog-to-digital converter start at a chosen point of a PWM period. A time base counter runs against a period register. In free-running mode it counts upward and wraps. In up/down (center-aligned) mode it climbs to the period and then falls back to zero. A trigger unit compares the counter with a programmable compare value. In up/down mode it accepts a match only in the selected counting phase. Accepted matches pass through a postscaler, and the block emits a one-clock start pulse toward the converter.

Software programs the block through a small write port with three registers: period, compare (with its direction-select bit) and control. The control register holds the count mode, the postscale ratio and an idle-stop bit. When idle-stop is set, an idle request freezes the counter and the trigger logic. A write to the compare register always restarts the postscaler, even when the value written is the same as before.

The counter is a two-state machine with the states PH_UP and PH_DOWN. Free-running mode keeps it in PH_UP, and the counter goes from the period back to 0. In up/down mode there are two transitions. TURN_TOP takes PH_UP to PH_DOWN when the counter reaches the period. TURN_BOTTOM takes PH_DOWN to PH_UP when the counter reaches 0. Each turnaround holds the counter value for one cycle. STEP_UP and STEP_DOWN move the counter by one inside a phase. FREEZE holds the state and the counter while the block is frozen.

Top module: `pwm_adc_trig`

## Requirements
- R1: In free-running mode (control bit 0 = 0) the counter runs 0, 1, …, P and then returns to 0, where P is the period register. One period is P+1 cycles.
- R2: In up/down mode (control bit 0 = 1) the counter runs 0..P in PH_UP and P..0 in PH_DOWN. The value at each end is held for one cycle while the phase flips, so one period is 2P+2 cycles. The first running cycle after reset is at 0 in PH_UP.
- R3: A match is a cycle in which the counter equals the compare value (compare register bits CNT_W-1:0). In free-running mode every match is accepted, and the direction-select bit has no effect.
- R4: In up/down mode the direction-select bit (compare register bit CNT_W) decides which matches are accepted. With 0, only matches in PH_UP count; with 1, only matches in PH_DOWN count. At a turnaround the counter equals the compare value in both phases, and each of those cycles is judged by its own phase.
- R5: Control bits 5:2 hold a postscale value N from 0 to 15. The output fires once per N+1 accepted matches, on the (N+1)-th match counted since the postscaler was last cleared.
- R6: Any write to the compare register clears the postscaler, even when the value written is unchanged. A match in the cycle of that write is discarded.
- R7: Reset clears the postscaler and holds adc_start low. Reset also sets period 0, compare to all ones, direction 0, free-running mode, idle-stop 0 and N 0, so no pulse is issued until the registers are written.
- R8: When control bit 1 (idle-stop) is 1 and idle_req is high, the counter, the phase and the postscaler hold and no pulse is issued. When idle-stop is 0, idle_req has no effect.
- R9: adc_start is high for the single cycle that follows a cycle holding the accepted match that completes the postscale count.
- R10: Register addresses: 0 is period (wr_data bits CNT_W-1:0), 1 is compare, 2 is control. A write takes effect at the next clock edge. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W+1 | Write data |
| idle_req | input | 1 | Idle request from the system |
| adc_start | output | 1 | Single-cycle converter start pulse |

## Verification
Two functions can land in the same cycle. The first pair is a compare write and a counter match: the bench writes the compare register, with the same value, on a cycle where the counter equals it. The pulse stream that follows is then judged against a model whose postscale count restarts at zero and which drops that match. The second pair is a freeze and a register write: a control write that clears idle-stop is issued while the block is frozen. The bench expects the block to stay frozen for that cycle and to run under the still-raised idle request afterwards. Around these cases, every combination of mode, direction, compare value and two postscale values is swept for small periods, and every cycle's output is compared with the counter position computed arithmetically.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
    typedef enum logic {
        PH_UP   = 1'b0,
        PH_DOWN = 1'b1
    } phase_e;

    localparam logic [1:0] SEL_PERIOD = 2'd0;
    localparam logic [1:0] SEL_CMP    = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
endpackage

// File: rtl/pwm_trig_regs.sv
module pwm_trig_regs
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W:0]   wr_data,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             dir_sel_q,
    output logic             mode_q,
    output logic             idle_stop_q,
    output logic [PS_W-1:0]  ps_ratio_q,
    output logic             cmp_wr
);
    localparam int PS_LO = 2;
    localparam int PS_HI = PS_LO + PS_W - 1;

    assign cmp_wr = wr_en && (wr_addr == SEL_CMP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q    <= '0;
            cmp_q       <= '1;
            dir_sel_q   <= 1'b0;
            mode_q      <= 1'b0;
            idle_stop_q <= 1'b0;
            ps_ratio_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                SEL_PERIOD: period_q <= wr_data[CNT_W-1:0];
                SEL_CMP: begin
                    cmp_q     <= wr_data[CNT_W-1:0];
                    dir_sel_q <= wr_data[CNT_W];
                end
                SEL_CTRL: begin
                    mode_q      <= wr_data[0];
                    idle_stop_q <= wr_data[1];
                    ps_ratio_q  <= wr_data[PS_HI:PS_LO];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_trig_timebase.sv
module pwm_trig_timebase
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mode_q,
    input  logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] cnt,
    output phase_e           phase
);
    phase_e           phase_nx;
    logic [CNT_W-1:0] cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_UP;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions: FREEZE, STEP_UP, STEP_DOWN, TURN_TOP, TURN_BOTTOM
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt;
        if (!run) begin
            phase_nx = phase;
            cnt_nx   = cnt;
        end else if (!mode_q) begin
            phase_nx = PH_UP;
            cnt_nx   = (cnt >= period_q) ? '0 : cnt + 1'b1;
        end else begin
            unique case (phase)
                PH_UP: begin
                    if (cnt >= period_q) begin
                        phase_nx = PH_DOWN;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_DOWN: begin
                    if (cnt == '0) begin
                        phase_nx = PH_UP;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                default: phase_nx = PH_UP;
            endcase
        end
    end
endmodule

// File: rtl/pwm_trig_event.sv
module pwm_trig_event
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  phase_e           phase,
    input  logic             mode_q,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             dir_sel_q,
    input  logic [PS_W-1:0]  ps_ratio_q,
    input  logic             cmp_wr,
    output logic [PS_W-1:0]  ps_cnt,
    output logic             adc_start
);
    logic   hit;
    logic   fire;
    phase_e want;

    always_comb begin
        want = dir_sel_q ? PH_DOWN : PH_UP;
        hit  = run && !cmp_wr && (cnt == cmp_q) && (!mode_q || (phase == want));
        fire = hit && (ps_cnt >= ps_ratio_q);
    end

    // postscaler state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_cnt <= '0;
        end else if (cmp_wr || fire) begin
            ps_cnt <= '0;
        end else if (hit) begin
            ps_cnt <= ps_cnt + 1'b1;
        end
    end

    // output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_start <= 1'b0;
        end else begin
            adc_start <= fire;
        end
    end
endmodule

// File: rtl/pwm_adc_trig.sv
module pwm_adc_trig
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [CNT_W:0] wr_data,
    input  logic           idle_req,
    output logic           adc_start
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cmp_q;
    logic             dir_sel_q;
    logic             mode_q;
    logic             idle_stop_q;
    logic [PS_W-1:0]  ps_ratio_q;
    logic             cmp_wr;
    logic             run;
    logic [CNT_W-1:0] cnt;
    phase_e           phase;
    logic [PS_W-1:0]  ps_cnt;

    assign run = !(idle_req && idle_stop_q);

    pwm_trig_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .period_q(period_q), .cmp_q(cmp_q),
        .dir_sel_q(dir_sel_q), .mode_q(mode_q), .idle_stop_q(idle_stop_q),
        .ps_ratio_q(ps_ratio_q), .cmp_wr(cmp_wr)
    );

    pwm_trig_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_q(mode_q),
        .period_q(period_q), .cnt(cnt), .phase(phase)
    );

    pwm_trig_event #(.CNT_W(CNT_W), .PS_W(PS_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .phase(phase),
        .mode_q(mode_q), .cmp_q(cmp_q), .dir_sel_q(dir_sel_q),
        .ps_ratio_q(ps_ratio_q), .cmp_wr(cmp_wr), .ps_cnt(ps_cnt),
        .adc_start(adc_start)
    );
endmodule

// File: rtl/pwm_adc_trig_chk.sv
module pwm_adc_trig_chk
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             idle_req,
    input logic             adc_start,
    input logic [CNT_W-1:0] cnt,
    input phase_e           phase,
    input logic [CNT_W-1:0] period_q,
    input logic             mode_q,
    input logic             idle_stop_q,
    input logic [PS_W-1:0]  ps_cnt,
    input logic [PS_W-1:0]  ps_ratio_q
);
    logic frozen;
    assign frozen = idle_req && idle_stop_q;

    // R8
    freeze_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(cnt));

    // R8
    freeze_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> !adc_start);

    // R6
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_CMP) |=> (ps_cnt == '0 && !adc_start));

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !mode_q && cnt >= period_q) |=> (cnt == '0));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && mode_q && phase == PH_UP && cnt < period_q)
        |=> (cnt == $past(cnt) + 1'b1));

    // R2
    turn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && mode_q && phase == PH_UP && cnt >= period_q)
        |=> (phase == PH_DOWN && $stable(cnt)));

    // R5
    ps_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($past(ps_cnt) >= $past(ps_ratio_q) && ps_cnt == '0));

    // R7
    always @(negedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            reset_chk: assert (ps_cnt == '0 && !adc_start);
        end
    end
endmodule

bind pwm_adc_trig pwm_adc_trig_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .idle_req(idle_req), .adc_start(adc_start), .cnt(cnt), .phase(phase),
    .period_q(period_q), .mode_q(mode_q), .idle_stop_q(idle_stop_q),
    .ps_cnt(ps_cnt), .ps_ratio_q(ps_ratio_q)
);

// File: tb/pwm_adc_trig_tb.sv
module pwm_adc_trig_tb;
    localparam int CNT_W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = 2'd0;
    logic [CNT_W:0] wr_data = '0;
    logic           idle_req = 1'b1;
    logic           adc_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench view of the programmed configuration and counter position
    int cfg_mode, cfg_dir, cfg_P, cfg_c, cfg_N, cfg_istop;
    int pos, mcount;

    pwm_adc_trig #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .idle_req(idle_req), .adc_start(adc_start)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: adc_start=%0b expected %0b (pos %0d mode %0d dir %0d P %0d c %0d N %0d)",
                     tag, got, exp, pos, cfg_mode, cfg_dir, cfg_P, cfg_c, cfg_N);
        end
    endtask

    function automatic bit model_match();
        int p, cv;
        bit up;
        if (cfg_mode == 0) begin
            p = pos % (cfg_P + 1);
            return p == cfg_c;
        end
        p = pos % (2 * cfg_P + 2);
        if (p <= cfg_P) begin
            cv = p;
            up = 1;
        end else begin
            cv = 2 * cfg_P + 1 - p;
            up = 0;
        end
        return (cv == cfg_c) && (cfg_dir != 0 ? !up : up);
    endfunction

    function automatic logic [CNT_W:0] ctrl_word(int n, int istop, int mode);
        logic [CNT_W:0] d = '0;
        d[5:2] = n[3:0];
        d[1]   = istop[0];
        d[0]   = mode[0];
        return d;
    endfunction

    task automatic raw_write(input logic [1:0] a, input logic [CNT_W:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one cycle of running under the bench model, with optional register write
    task automatic step(input logic idle, input logic we, input logic [1:0] wa,
                        input logic [CNT_W:0] wd, input string tag);
        bit frz, m, cw, exp;
        frz = idle && (cfg_istop != 0);
        m   = !frz && model_match();
        cw  = we && (wa == 2'd1);
        exp = 0;
        if (cw) mcount = 0;
        else if (m) begin
            if (mcount >= cfg_N) begin exp = 1; mcount = 0; end
            else mcount++;
        end
        idle_req = idle; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check(adc_start, exp, tag);
        if (!frz) pos++;
        if (we) begin
            if (wa == 2'd0) cfg_P = int'(wd[CNT_W-1:0]);
            if (wa == 2'd1) begin cfg_c = int'(wd[CNT_W-1:0]); cfg_dir = int'(wd[CNT_W]); end
            if (wa == 2'd2) begin cfg_N = int'(wd[5:2]); cfg_istop = int'(wd[1]); cfg_mode = int'(wd[0]); end
        end
    endtask

    task automatic run(input int n, input logic idle, input string tag);
        for (int i = 0; i < n; i++) step(idle, 1'b0, 2'd0, '0, tag);
    endtask

    // reset, then program the block while frozen at counter 0 in the up phase
    task automatic setup(input int mode, input int dir, input int p, input int c, input int n);
        logic [CNT_W:0] cw;
        rst_n = 1'b0; idle_req = 1'b1; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check(adc_start, 1'b0, "R7 reset");
        rst_n = 1'b1;
        raw_write(2'd2, ctrl_word(n, 1, mode));
        check(adc_start, 1'b0, "R7 after reset");
        raw_write(2'd0, (CNT_W+1)'(p));
        cw = (CNT_W+1)'(c);
        cw[CNT_W] = dir[0];
        raw_write(2'd1, cw);
        cfg_mode = mode; cfg_dir = dir; cfg_P = p; cfg_c = c; cfg_N = n; cfg_istop = 1;
        pos = 0; mcount = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [CNT_W:0] d;
        // R7: defaults produce no pulse
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(adc_start, 1'b0, "R7 in reset");
        rst_n = 1'b1; idle_req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(adc_start, 1'b0, "R7 defaults idle");
        end

        // sweep: R1 R2 R3 R4 R5 R9
        for (int mode = 0; mode < 2; mode++)
            for (int dir = 0; dir < 2; dir++)
                for (int pi = 0; pi < 2; pi++)
                    for (int c = 0; c <= (pi == 0 ? 2 : 4); c++)
                        for (int ni = 0; ni < 2; ni++) begin
                            int p, n, lp;
                            p  = (pi == 0) ? 2 : 4;
                            n  = (ni == 0) ? 0 : 2;
                            lp = (mode != 0) ? 2 * p + 2 : p + 1;
                            setup(mode, dir, p, c, n);
                            run(2 * (n + 1) * lp + 2, 1'b0,
                                mode != 0 ? "R2 R4 R9 sweep" : "R1 R3 R5 sweep");
                        end

        // R8: freeze mid-run in up/down mode
        setup(1, 1, 3, 1, 1);
        run(9, 1'b0, "R8 before freeze");
        run(6, 1'b1, "R8 frozen");
        run(24, 1'b0, "R8 after freeze");

        // R8: idle-stop cleared while frozen, then idle has no effect
        setup(1, 0, 2, 2, 0);
        step(1'b1, 1'b1, 2'd2, ctrl_word(0, 0, 1), "R8 ctrl write while frozen");
        run(20, 1'b1, "R8 idle ignored");

        // R6: same-value compare rewrite on a matching cycle
        setup(0, 0, 3, 1, 3);
        run(9, 1'b0, "R6 before rewrite");
        d = (CNT_W+1)'(1);
        step(1'b0, 1'b1, 2'd1, d, "R6 rewrite discards match");
        run(34, 1'b0, "R6 postscaler restarted");

        // R5: largest postscale value
        setup(0, 0, 1, 0, 15);
        run(70, 1'b0, "R5 ratio 1:16");

        // R10: address 3 ignored, free mode ignores direction bit (R3)
        setup(0, 1, 4, 3, 1);
        run(7, 1'b0, "R10 before");
        step(1'b0, 1'b1, 2'd3, '1, "R10 addr3 write");
        run(25, 1'b0, "R10 addr3 ignored");

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule